// File: doc/BRIEF.md
# Line Refill Controller

This block serves cache line fills from a modelled main memory reached over a slow clocked bus. A requester presents a line address. The controller then walks the bus through three kinds of phase. First comes one address cycle. Then come one or more DRAM access windows, and last the word transfer cycles. It hands the line's words back in ascending order, with one strobe bit per word. A mode input, sampled when the request is taken, selects how the memory is organised: one word wide, a whole line wide, or a set of interleaved banks. The choice changes how accesses and transfers overlap, and so how long a fill takes.

The bus does not run at the core clock. A programmable divider produces a bus-cycle enable, and every phase counter advances only on that enable. The divider restarts when a request is taken, so the fill latency in core clocks is an exact multiple of the bus-cycle count. The bus-cycle total of the most recent fill is reported on an output, and it holds until the next fill completes. The memory model is computed, not stored: each word holds its own word address.

Top module: `line_refill_ctrl`

## Requirements
- R1: After a synchronous reset, busy_o, done_o, word_mask_o, line_o and cycles_o are all zero.
- R2: A request is taken on a clock edge where req_i is high and busy_o is low, and busy_o is high after that edge. mode_i and addr_i are sampled only at that edge. busy_o is low again in the cycle where done_o is high.
- R3: With mode_i = 2'b00 (one word wide) the accesses run one after another, each followed by its transfer, so a 4-word fill takes 1 + 4*15 + 4 = 65 bus cycles and cycles_o reads 65.
- R4: With mode_i = 2'b01 (line wide) one 15-cycle access is followed by a single transfer cycle that sets all word_mask_o bits together, for 17 bus cycles.
- R5: With mode_i = 2'b10 (interleaved banks) all banks are accessed at once, then words go out one per bus cycle, for 20 bus cycles.
- R6: mode_i = 2'b11 behaves exactly like mode 2'b00.
- R7: One bus cycle lasts div_i + 1 core clocks. A fill of N bus cycles raises done_o exactly N*(div_i+1) clock edges after the edge on which the request was taken.
- R8: Words are delivered in ascending order. Outside line-wide mode exactly one word_mask_o bit is set per transfer. When bit w is set, line_o[w*WORD_W +: WORD_W] holds line*LINE_WORDS + w, where line is the requested line address and LINE_WORDS is a power of two.
- R9: done_o is high for one cycle, in the same cycle as the strobe for the last word. cycles_o changes only in that cycle and then holds.
- R10: req_i, addr_i and mode_i changes while busy_o is high do not restart the fill, do not alter its timing and do not alter its data.
- R11: Word w is strobed at the end of bus cycle 17 + 16*w in one-word-wide mode, and at the end of bus cycle 17 + w in interleaved mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| div_i | input | DIV_W | Bus cycle length minus one, in core clocks |
| mode_i | input | 2 | Memory organisation: 00 one word wide, 01 line wide, 10 interleaved, 11 as 00 |
| req_i | input | 1 | Fill request |
| addr_i | input | LINE_W | Line address of the fill |
| busy_o | output | 1 | Fill in progress |
| word_mask_o | output | LINE_WORDS | One-cycle strobe per delivered word |
| line_o | output | LINE_WORDS*WORD_W | Line data; slice w is valid while strobe bit w is set |
| done_o | output | 1 | One-cycle pulse with the last word |
| cycles_o | output | CYC_W | Bus cycles taken by the last completed fill |

## Verification
Several rules are checked on every cycle. A strobe is either a single bit or the full line. done_o always coincides with the last word's strobe, and the controller is idle in that cycle. A fill never ends with a bus-cycle total other than 65, 17 or 20. cycles_o never moves outside a done pulse. Other behaviour only the directed scenarios can show: the exact clock edge of every word under each mode and divider setting, the word values and their order, the reserved mode code, and that a request or mode change in mid-fill leaves the fill untouched.

// File: rtl/refill_pkg.sv
package refill_pkg;

  typedef enum logic [1:0] {
    MODE_NARROW = 2'b00,
    MODE_WIDE   = 2'b01,
    MODE_BANKED = 2'b10,
    MODE_SPARE  = 2'b11
  } fill_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'b00,
    ST_ADDR   = 2'b01,
    ST_ACCESS = 2'b10,
    ST_XFER   = 2'b11
  } fill_state_e;

endpackage

// File: rtl/refill_tick.sv
module refill_tick #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);

  logic [DIV_W-1:0] cnt_q;

  assign tick_o = (cnt_q == div_i);

  always_ff @(posedge clk) begin
    if (rst || restart_i) begin
      cnt_q <= '0;
    end else if (tick_o) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/refill_bank.sv
module refill_bank #(
  parameter int LINE_W = 12,
  parameter int WORD_W = 32,
  parameter int IDX_W  = 2,
  parameter int BANK   = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [LINE_W-1:0] line_i,
  output logic [WORD_W-1:0] q_o
);

  localparam logic [IDX_W-1:0] BANK_ID = IDX_W'(BANK);

  // word value equals its own word address
  always_ff @(posedge clk) begin
    if (rst) begin
      q_o <= '0;
    end else if (load_i) begin
      q_o <= WORD_W'({line_i, BANK_ID});
    end
  end

endmodule

// File: rtl/refill_seq.sv
module refill_seq
  import refill_pkg::*;
#(
  parameter int LINE_WORDS = 4,
  parameter int ACCESS_CYC = 15,
  parameter int CYC_W      = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  tick_i,
  input  logic                  req_i,
  input  logic [1:0]            mode_i,
  output logic                  busy_o,
  output logic                  start_o,
  output logic [LINE_WORDS-1:0] load_o,
  output logic [LINE_WORDS-1:0] xfer_o,
  output logic                  last_o,
  output logic [CYC_W-1:0]      cyc_o
);

  localparam int IDX_W = (LINE_WORDS > 1) ? $clog2(LINE_WORDS) : 1;
  localparam int ACC_W = $clog2(ACCESS_CYC + 1);
  localparam logic [ACC_W-1:0] ACC_LAST = ACC_W'(ACCESS_CYC - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(LINE_WORDS - 1);
  localparam logic [LINE_WORDS-1:0] ONE = {{(LINE_WORDS-1){1'b0}}, 1'b1};

  fill_state_e      st_q;
  logic             narrow_q;
  logic             wide_q;
  logic [IDX_W-1:0] idx_q;
  logic [ACC_W-1:0] acc_q;
  logic [CYC_W-1:0] cyc_q;
  fill_mode_e       mode_in;

  assign mode_in = fill_mode_e'(mode_i);
  assign busy_o  = (st_q != ST_IDLE);
  assign start_o = (st_q == ST_IDLE) && req_i;
  assign cyc_o   = cyc_q + CYC_W'(1);

  always_comb begin
    load_o = '0;
    xfer_o = '0;
    last_o = 1'b0;
    if (tick_i) begin
      case (st_q)
        ST_ACCESS: begin
          if (acc_q == ACC_LAST) begin
            load_o = narrow_q ? (ONE << idx_q) : '1;
          end
        end
        ST_XFER: begin
          xfer_o = wide_q ? '1 : (ONE << idx_q);
          last_o = wide_q || (idx_q == IDX_LAST);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_IDLE;
      narrow_q <= 1'b0;
      wide_q   <= 1'b0;
      idx_q    <= '0;
      acc_q    <= '0;
      cyc_q    <= '0;
    end else if (st_q == ST_IDLE) begin
      if (req_i) begin
        st_q     <= ST_ADDR;
        narrow_q <= (mode_in == MODE_NARROW) || (mode_in == MODE_SPARE);
        wide_q   <= (mode_in == MODE_WIDE);
        idx_q    <= '0;
        acc_q    <= '0;
        cyc_q    <= '0;
      end
    end else if (tick_i) begin
      cyc_q <= cyc_o;
      case (st_q)
        ST_ADDR: begin
          st_q  <= ST_ACCESS;
          acc_q <= '0;
        end
        ST_ACCESS: begin
          if (acc_q == ACC_LAST) begin
            st_q <= ST_XFER;
          end else begin
            acc_q <= acc_q + 1'b1;
          end
        end
        ST_XFER: begin
          if (last_o) begin
            st_q <= ST_IDLE;
          end else begin
            idx_q <= idx_q + 1'b1;
            if (narrow_q) begin
              st_q  <= ST_ACCESS;
              acc_q <= '0;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/line_refill_ctrl.sv
module line_refill_ctrl #(
  parameter int LINE_WORDS = 4,
  parameter int WORD_W     = 32,
  parameter int LINE_W     = 12,
  parameter int ACCESS_CYC = 15,
  parameter int DIV_W      = 4,
  parameter int CYC_W      = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [DIV_W-1:0]             div_i,
  input  logic [1:0]                   mode_i,
  input  logic                         req_i,
  input  logic [LINE_W-1:0]            addr_i,
  output logic                         busy_o,
  output logic [LINE_WORDS-1:0]        word_mask_o,
  output logic [LINE_WORDS*WORD_W-1:0] line_o,
  output logic                         done_o,
  output logic [CYC_W-1:0]             cycles_o
);

  localparam int IDX_W = (LINE_WORDS > 1) ? $clog2(LINE_WORDS) : 1;

  logic                  tick;
  logic                  start;
  logic [LINE_WORDS-1:0] load;
  logic [LINE_WORDS-1:0] xfer;
  logic                  last;
  logic [CYC_W-1:0]      cyc;
  logic [LINE_W-1:0]     line_q;
  logic [WORD_W-1:0]     bank_q [LINE_WORDS];

  refill_tick #(.DIV_W(DIV_W)) u_tick (
    .clk       (clk),
    .rst       (rst),
    .restart_i (start),
    .div_i     (div_i),
    .tick_o    (tick)
  );

  refill_seq #(
    .LINE_WORDS (LINE_WORDS),
    .ACCESS_CYC (ACCESS_CYC),
    .CYC_W      (CYC_W)
  ) u_seq (
    .clk     (clk),
    .rst     (rst),
    .tick_i  (tick),
    .req_i   (req_i),
    .mode_i  (mode_i),
    .busy_o  (busy_o),
    .start_o (start),
    .load_o  (load),
    .xfer_o  (xfer),
    .last_o  (last),
    .cyc_o   (cyc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q <= '0;
    end else if (start) begin
      line_q <= addr_i;
    end
  end

  for (genvar b = 0; b < LINE_WORDS; b++) begin : g_bank
    refill_bank #(
      .LINE_W (LINE_W),
      .WORD_W (WORD_W),
      .IDX_W  (IDX_W),
      .BANK   (b)
    ) u_bank (
      .clk    (clk),
      .rst    (rst),
      .load_i (load[b]),
      .line_i (line_q),
      .q_o    (bank_q[b])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      word_mask_o <= '0;
      done_o      <= 1'b0;
      cycles_o    <= '0;
      line_o      <= '0;
    end else begin
      word_mask_o <= xfer;
      done_o      <= last;
      if (last) begin
        cycles_o <= cyc;
      end
      for (int w = 0; w < LINE_WORDS; w++) begin
        if (xfer[w]) begin
          line_o[w*WORD_W +: WORD_W] <= bank_q[w];
        end
      end
    end
  end

endmodule

// File: rtl/line_refill_ctrl_chk.sv
module line_refill_ctrl_chk #(
  parameter int LINE_WORDS = 4,
  parameter int ACCESS_CYC = 15,
  parameter int CYC_W      = 8
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  busy_o,
  input logic [LINE_WORDS-1:0] word_mask_o,
  input logic                  done_o,
  input logic [CYC_W-1:0]      cycles_o
);

  localparam int NARROW_N = 1 + LINE_WORDS * ACCESS_CYC + LINE_WORDS;
  localparam int WIDE_N   = 1 + ACCESS_CYC + 1;
  localparam int BANKED_N = 1 + ACCESS_CYC + LINE_WORDS;

  assert_done_with_last_R9: assert property (@(posedge clk) disable iff (rst)
    done_o |-> word_mask_o[LINE_WORDS-1]);

  assert_strobe_shape_R8: assert property (@(posedge clk) disable iff (rst)
    (word_mask_o != '0) |-> (($countones(word_mask_o) == 1) || (word_mask_o == '1)));

  // R3, R4, R5: a fill ends only with one of the three organisation totals
  assert_fill_length_R3: assert property (@(posedge clk) disable iff (rst)
    done_o |-> ((cycles_o == CYC_W'(NARROW_N)) || (cycles_o == CYC_W'(WIDE_N)) ||
                (cycles_o == CYC_W'(BANKED_N))));

  assert_cycles_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> $stable(cycles_o));

  assert_idle_at_done_R2: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);

  assert_strobe_inside_fill_R10: assert property (@(posedge clk) disable iff (rst)
    ((word_mask_o != '0) && !done_o) |-> busy_o);

endmodule

bind line_refill_ctrl line_refill_ctrl_chk #(
  .LINE_WORDS (LINE_WORDS),
  .ACCESS_CYC (ACCESS_CYC),
  .CYC_W      (CYC_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .busy_o      (busy_o),
  .word_mask_o (word_mask_o),
  .done_o      (done_o),
  .cycles_o    (cycles_o)
);

// File: tb/tb_line_refill_ctrl.sv
module tb_line_refill_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int LW     = 4;
  localparam int WORD_W = 32;
  localparam int LINE_W = 12;
  localparam int DIV_W  = 4;
  localparam int CYC_W  = 8;

  logic                   clk = 1'b0;
  logic                   rst = 1'b1;
  logic [DIV_W-1:0]       div_i = '0;
  logic [1:0]             mode_i = 2'b00;
  logic                   req_i = 1'b0;
  logic [LINE_W-1:0]      addr_i = '0;
  logic                   busy_o;
  logic [LW-1:0]          word_mask_o;
  logic [LW*WORD_W-1:0]   line_o;
  logic                   done_o;
  logic [CYC_W-1:0]       cycles_o;

  int n_checks = 0;
  int n_fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  line_refill_ctrl #(
    .LINE_WORDS (LW),
    .WORD_W     (WORD_W),
    .LINE_W     (LINE_W),
    .ACCESS_CYC (15),
    .DIV_W      (DIV_W),
    .CYC_W      (CYC_W)
  ) dut (
    .clk         (clk),
    .rst         (rst),
    .div_i       (div_i),
    .mode_i      (mode_i),
    .req_i       (req_i),
    .addr_i      (addr_i),
    .busy_o      (busy_o),
    .word_mask_o (word_mask_o),
    .line_o      (line_o),
    .done_o      (done_o),
    .cycles_o    (cycles_o)
  );

  task automatic check(input bit ok, input string what, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
  endtask

  // expected bus cycle at whose end word w is strobed
  function automatic int word_tick(input logic [1:0] m, input int w);
    if (m == 2'b01) return 17;
    if (m == 2'b10) return 17 + w;
    return 17 + 16 * w;
  endfunction

  task automatic run_fill(input logic [1:0] m, input int line, input int dv,
                          input int exp_n, input string tag, input bit intrude);
    int k = 0;
    int nw = 0;
    bit got_done = 1'b0;
    @(negedge clk);
    mode_i = m;
    addr_i = LINE_W'(line);
    div_i  = DIV_W'(dv);
    req_i  = 1'b1;
    @(posedge clk);
    #1;
    req_i = 1'b0;
    check(busy_o == 1'b1, "R2 busy after accept", busy_o, 1);
    while (!got_done && k < 5000) begin
      @(posedge clk);
      #1;
      k++;
      if (intrude && k == 4) begin
        req_i  = 1'b1;
        addr_i = LINE_W'(line ^ 12'h5A5);
        mode_i = 2'b01;
      end
      if (intrude && k == 9) begin
        req_i  = 1'b0;
        mode_i = 2'b10;
      end
      if (word_mask_o != '0) begin
        for (int w = 0; w < LW; w++) begin
          if (word_mask_o[w]) begin
            check(w == nw, {tag, " R8 word order"}, w, nw);
            check(k == word_tick(m, w) * (dv + 1), {tag, " R11 word strobe edge"}, k,
                  word_tick(m, w) * (dv + 1));
            check(line_o[w*WORD_W +: WORD_W] == WORD_W'(line * LW + w),
                  {tag, " R8 word data"}, line_o[w*WORD_W +: WORD_W], line * LW + w);
            nw++;
          end
        end
      end
      if (done_o) got_done = 1'b1;
    end
    req_i = 1'b0;
    check(got_done, {tag, " R9 done seen"}, got_done, 1);
    check(nw == LW, {tag, " R8 all words delivered"}, nw, LW);
    check(k == exp_n * (dv + 1), {tag, " R7 done latency edges"}, k, exp_n * (dv + 1));
    check(cycles_o == CYC_W'(exp_n), {tag, " bus cycle total"}, cycles_o, exp_n);
    @(posedge clk);
    #1;
    check(done_o == 1'b0 && word_mask_o == '0, {tag, " R9 done one cycle"}, done_o, 0);
    check(busy_o == 1'b0, {tag, " R2 idle after fill"}, busy_o, 0);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check(busy_o == 1'b0, "R1 busy at reset", busy_o, 0);
    check(done_o == 1'b0, "R1 done at reset", done_o, 0);
    check(word_mask_o == '0, "R1 strobes at reset", word_mask_o, 0);
    check(line_o == '0, "R1 line at reset", line_o[31:0], 0);
    check(cycles_o == '0, "R1 cycles at reset", cycles_o, 0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_narrow();
    run_fill(2'b00, 12'h123, 0, 65, "R3 one-word-wide", 1'b0);
  endtask

  task automatic t_wide();
    run_fill(2'b01, 12'h0A7, 0, 17, "R4 line-wide", 1'b0);
  endtask

  task automatic t_banked();
    run_fill(2'b10, 12'hFFF, 0, 20, "R5 interleaved", 1'b0);
  endtask

  task automatic t_spare();
    run_fill(2'b11, 12'h040, 0, 65, "R6 spare code", 1'b0);
  endtask

  task automatic t_divider();
    run_fill(2'b10, 12'h311, 2, 20, "R7 div2 interleaved", 1'b0);
    run_fill(2'b00, 12'h002, 1, 65, "R7 div1 one-word-wide", 1'b0);
    run_fill(2'b01, 12'h800, 3, 17, "R7 div3 line-wide", 1'b0);
  endtask

  task automatic t_busy_ignore();
    run_fill(2'b00, 12'h3C3, 0, 65, "R10 mid-fill request", 1'b0 | 1'b1);
  endtask

  task automatic t_hold();
    run_fill(2'b01, 12'h015, 0, 17, "R9 hold setup", 1'b0);
    @(negedge clk);
    mode_i = 2'b00;
    div_i  = 4'd5;
    repeat (12) @(posedge clk);
    #1;
    check(cycles_o == CYC_W'(17), "R9 cycles_o held while idle", cycles_o, 17);
    check(busy_o == 1'b0, "R2 no fill without request", busy_o, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    t_reset();
    t_narrow();
    t_wide();
    t_banked();
    t_spare();
    t_divider();
    t_busy_ignore();
    t_hold();
    summary();
    $finish;
  end

endmodule